// File: doc/BRIEF.md
# Page Access-Control Trap Checker

This block judges a single memory reference against the 3-bit access-control code of the page descriptor that the reference selects. In the same cycle it gives one of three outcomes: let the reference proceed, let it proceed and raise a memory-management trap, or abort it. At the next clock edge it records the side effects. These are the per-page accessed and written bits and the management status fields: three abort flags, a trap flag and the number of the page involved.

The page-length test is part of the block. The reference supplies a block number, the page's length field and the expansion direction. A reference that would otherwise be allowed aborts when its block lies outside the page. The status fields freeze while any abort flag is set, so software can examine the first fault. Software clears the status through a clear input. A descriptor's history bits are cleared when that descriptor is reloaded.

Top module: `pg_access_guard`

## Requirements
- R1: Access codes 0, 3 and 7 are non-resident. A reference with such a code aborts (outcome 2'b10) and sets abort flag bit 2 (non-resident).
- R2: A write to a page with code 1 or 2 (read-only) aborts and sets abort flag bit 0 (read-only). A read of such a page does not abort for this reason.
- R3: A reference that is not already aborted by R1 or R2 aborts with abort flag bit 1 (length) when its block number is below the length field while `expand_down` is 1, or above the length field while `expand_down` is 0. Each abort sets exactly one flag.
- R4: A read of code 1 or 4, or a write of code 4 or 5, is trap-class. It sets the page's accessed bit and the status trap flag whatever `trap_enable` is. Its outcome is 2'b01 (trap) unless R3 aborts it.
- R5: `trap_req` is 1 only for a trap-class reference made while `trap_enable` is 1 and the status trap flag was 0 before the reference.
- R6: A trap-class reference made with `trap_enable` set loads its page number into `stat_page` only while the status is not frozen.
- R7: An abort ORs its flag into `stat_abort` and loads `stat_page` only while the status is not frozen. The outcome is abort either way.
- R8: A write that does not abort sets the page's written bit. An aborted write leaves it unchanged.
- R9: The status is frozen whenever any bit of `stat_abort` is 1. While frozen, `stat_abort` and `stat_page` hold, but the trap flag can still be set.
- R10: Reset clears all status fields and all accessed and written bits. `stat_clear` zeroes the status fields. `desc_clear` zeroes both bits of page `desc_clear_page`. Both clears take priority over a reference in the same cycle.
- R11: With `ref_valid` low, the outcome is proceed (2'b00), `trap_req` is 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_code | input | 3 | Access-control code of the selected descriptor |
| ref_page | input | PAGE_W | Index of the selected descriptor |
| ref_write | input | 1 | 1 for write, 0 for read |
| trap_enable | input | 1 | Management traps enabled |
| blk_num | input | BLK_W | Block number of the address within the page |
| pg_len | input | BLK_W | Length field of the descriptor |
| expand_down | input | 1 | Page grows downward |
| stat_clear | input | 1 | Zero the status fields |
| desc_clear | input | 1 | Zero the history bits of one descriptor |
| desc_clear_page | input | PAGE_W | Descriptor to clear |
| outcome | output | 2 | 00 proceed, 01 trap, 10 abort |
| trap_req | output | 1 | Management trap request |
| stat_abort | output | 3 | Abort flags: [2] non-resident, [1] length, [0] read-only |
| stat_trap | output | 1 | Status trap flag |
| stat_page | output | PAGE_W | Page number recorded in status |
| acc_bits | output | NPAGE | Accessed bit per descriptor |
| wr_bits | output | NPAGE | Written bit per descriptor |

## Verification
The bench builds the block with NPAGE=8 and BLK_W=3. That makes every pairing of block number, length field and direction enumerable. The sweep crosses all of them with all eight access codes, both access types and both trap-enable states. Status clears and descriptor clears are spread through the sweep at different rates. As a result, references arrive with the status frozen and unfrozen, with the trap flag already set and clear, and with history bits already set. The first-trap gating and the freeze rules are therefore both exercised on every code.

// File: rtl/pag_pkg.sv
package pag_pkg;

    typedef enum logic [1:0] {
        OUT_GO    = 2'b00,
        OUT_TRAP  = 2'b01,
        OUT_ABORT = 2'b10
    } outcome_e;

    typedef struct packed {
        logic nonres;
        logic length;
        logic rdonly;
    } fault_t;

    typedef struct packed {
        fault_t   fault;
        logic     trap_class;
        outcome_e result;
    } verdict_t;

    function automatic logic code_nonres(input logic [2:0] code);
        return (code == 3'd0) || (code == 3'd3) || (code == 3'd7);
    endfunction

    function automatic logic code_rdonly(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2);
    endfunction

    function automatic logic code_traps(input logic [2:0] code, input logic is_wr);
        if (is_wr)
            return (code == 3'd4) || (code == 3'd5);
        else
            return (code == 3'd1) || (code == 3'd4);
    endfunction

endpackage

// File: rtl/pag_len_cmp.sv
module pag_len_cmp #(
    parameter int BLK_W = 7
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [BLK_W-1:0] len,
    input  logic             down,
    output logic             outside
);
    always_comb begin
        if (down)
            outside = (blk < len);
        else
            outside = (blk > len);
    end
endmodule

// File: rtl/pag_classify.sv
module pag_classify
    import pag_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] code,
    input  logic       is_wr,
    input  logic       len_err,
    output verdict_t   verdict
);
    logic nr, ro, pl, tc;

    always_comb begin
        nr = code_nonres(code);
        ro = !nr && is_wr && code_rdonly(code);
        pl = !nr && !ro && len_err;
        tc = !nr && !ro && code_traps(code, is_wr);

        verdict.fault.nonres = valid && nr;
        verdict.fault.rdonly = valid && ro;
        verdict.fault.length = valid && pl;
        verdict.trap_class   = valid && tc;

        if (!valid)
            verdict.result = OUT_GO;
        else if (nr || ro || pl)
            verdict.result = OUT_ABORT;
        else if (tc)
            verdict.result = OUT_TRAP;
        else
            verdict.result = OUT_GO;
    end
endmodule

// File: rtl/pag_desc_bits.sv
module pag_desc_bits #(
    parameter int NPAGE = 16,
    localparam int PAGE_W = $clog2(NPAGE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [PAGE_W-1:0] upd_page,
    input  logic              set_acc,
    input  logic              set_wr,
    input  logic              clr_en,
    input  logic [PAGE_W-1:0] clr_page,
    output logic [NPAGE-1:0]  acc,
    output logic [NPAGE-1:0]  wrt
);
    for (genvar i = 0; i < NPAGE; i++) begin : g_page
        logic hit_upd, hit_clr;
        assign hit_upd = upd_en && (upd_page == PAGE_W'(i));
        assign hit_clr = clr_en && (clr_page == PAGE_W'(i));

        always_ff @(posedge clk) begin
            if (rst || hit_clr) begin
                acc[i] <= 1'b0;
                wrt[i] <= 1'b0;
            end else if (hit_upd) begin
                if (set_acc) acc[i] <= 1'b1;
                if (set_wr)  wrt[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pag_status.sv
module pag_status
    import pag_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  verdict_t          verdict,
    input  logic              trap_en,
    input  logic [PAGE_W-1:0] page,
    output logic [2:0]        abort_flags,
    output logic              trap_flag,
    output logic [PAGE_W-1:0] page_rec,
    output logic              frozen
);
    logic [2:0] err_vec;
    logic       aborting;

    assign frozen   = |abort_flags;
    assign err_vec  = {verdict.fault.nonres, verdict.fault.length, verdict.fault.rdonly};
    assign aborting = |err_vec;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            abort_flags <= '0;
            trap_flag   <= 1'b0;
            page_rec    <= '0;
        end else begin
            if (verdict.trap_class)
                trap_flag <= 1'b1;
            if (!frozen) begin
                if (aborting) begin
                    abort_flags <= abort_flags | err_vec;
                    page_rec    <= page;
                end else if (verdict.trap_class && trap_en) begin
                    page_rec    <= page;
                end
            end
        end
    end
endmodule

// File: rtl/pg_access_guard.sv
module pg_access_guard
    import pag_pkg::*;
#(
    parameter int NPAGE = 16,
    parameter int BLK_W = 7,
    localparam int PAGE_W = $clog2(NPAGE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_valid,
    input  logic [2:0]        ref_code,
    input  logic [PAGE_W-1:0] ref_page,
    input  logic              ref_write,
    input  logic              trap_enable,
    input  logic [BLK_W-1:0]  blk_num,
    input  logic [BLK_W-1:0]  pg_len,
    input  logic              expand_down,
    input  logic              stat_clear,
    input  logic              desc_clear,
    input  logic [PAGE_W-1:0] desc_clear_page,
    output logic [1:0]        outcome,
    output logic              trap_req,
    output logic [2:0]        stat_abort,
    output logic              stat_trap,
    output logic [PAGE_W-1:0] stat_page,
    output logic [NPAGE-1:0]  acc_bits,
    output logic [NPAGE-1:0]  wr_bits
);
    logic     len_err;
    verdict_t verdict;
    logic     frozen;
    logic     commit_wr;

    pag_len_cmp #(.BLK_W(BLK_W)) u_len (
        .blk     (blk_num),
        .len     (pg_len),
        .down    (expand_down),
        .outside (len_err)
    );

    pag_classify u_cls (
        .valid   (ref_valid),
        .code    (ref_code),
        .is_wr   (ref_write),
        .len_err (len_err),
        .verdict (verdict)
    );

    pag_status #(.PAGE_W(PAGE_W)) u_stat (
        .clk         (clk),
        .rst         (rst),
        .clear       (stat_clear),
        .verdict     (verdict),
        .trap_en     (trap_enable),
        .page        (ref_page),
        .abort_flags (stat_abort),
        .trap_flag   (stat_trap),
        .page_rec    (stat_page),
        .frozen      (frozen)
    );

    assign commit_wr = ref_write && (verdict.result != OUT_ABORT);

    pag_desc_bits #(.NPAGE(NPAGE)) u_desc (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (ref_valid),
        .upd_page (ref_page),
        .set_acc  (verdict.trap_class),
        .set_wr   (commit_wr),
        .clr_en   (desc_clear),
        .clr_page (desc_clear_page),
        .acc      (acc_bits),
        .wrt      (wr_bits)
    );

    assign outcome  = verdict.result;
    assign trap_req = verdict.trap_class && trap_enable && !stat_trap;

endmodule

// File: rtl/pg_access_guard_sva.sv
module pg_access_guard_sva #(
    parameter int NPAGE = 16,
    parameter int BLK_W = 7,
    localparam int PAGE_W = $clog2(NPAGE)
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_valid,
    input logic [2:0]        ref_code,
    input logic [PAGE_W-1:0] ref_page,
    input logic              ref_write,
    input logic              trap_enable,
    input logic [BLK_W-1:0]  blk_num,
    input logic [BLK_W-1:0]  pg_len,
    input logic              expand_down,
    input logic              stat_clear,
    input logic              desc_clear,
    input logic [1:0]        outcome,
    input logic              trap_req,
    input logic [2:0]        stat_abort,
    input logic              stat_trap,
    input logic [PAGE_W-1:0] stat_page,
    input logic [NPAGE-1:0]  wr_bits
);
    AST_NONRES_ABORTS: assert property (@(posedge clk) disable iff (rst)
        ref_valid && (ref_code == 3'd0 || ref_code == 3'd3 || ref_code == 3'd7)
        |-> outcome == 2'b10); // R1

    AST_RDONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        ref_valid && ref_write && (ref_code == 3'd1 || ref_code == 3'd2)
        |-> outcome == 2'b10); // R2

    AST_OUTSIDE_PAGE: assert property (@(posedge clk) disable iff (rst)
        ref_valid && (expand_down ? (blk_num < pg_len) : (blk_num > pg_len))
        |-> outcome == 2'b10); // R3

    AST_TRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ref_valid && outcome == 2'b01 && !stat_clear |=> stat_trap); // R4

    AST_FIRST_TRAP_ONLY: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> trap_enable && !stat_trap && ref_valid); // R5

    AST_TRAP_PAGE: assert property (@(posedge clk) disable iff (rst)
        ref_valid && trap_enable && outcome == 2'b01 && stat_abort == 3'b000 && !stat_clear
        |=> stat_page == $past(ref_page)); // R6

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stat_abort)); // R7

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        stat_abort != 3'b000 && !stat_clear
        |=> $stable(stat_abort) && $stable(stat_page)); // R9

    AST_WRITE_MARK: assert property (@(posedge clk) disable iff (rst)
        ref_valid && ref_write && outcome != 2'b10 && !desc_clear
        |=> wr_bits[$past(ref_page)]); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |-> outcome == 2'b00 && !trap_req); // R11

endmodule

bind pg_access_guard pg_access_guard_sva #(.NPAGE(NPAGE), .BLK_W(BLK_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .ref_valid   (ref_valid),
    .ref_code    (ref_code),
    .ref_page    (ref_page),
    .ref_write   (ref_write),
    .trap_enable (trap_enable),
    .blk_num     (blk_num),
    .pg_len      (pg_len),
    .expand_down (expand_down),
    .stat_clear  (stat_clear),
    .desc_clear  (desc_clear),
    .outcome     (outcome),
    .trap_req    (trap_req),
    .stat_abort  (stat_abort),
    .stat_trap   (stat_trap),
    .stat_page   (stat_page),
    .wr_bits     (wr_bits)
);

// File: tb/pg_access_guard_bench.sv
module pg_access_guard_bench;
    localparam int NP = 8;
    localparam int BW = 3;
    localparam int PW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_valid = 1'b0;
    logic [2:0]    ref_code = '0;
    logic [PW-1:0] ref_page = '0;
    logic          ref_write = 1'b0;
    logic          trap_enable = 1'b0;
    logic [BW-1:0] blk_num = '0;
    logic [BW-1:0] pg_len = '0;
    logic          expand_down = 1'b0;
    logic          stat_clear = 1'b0;
    logic          desc_clear = 1'b0;
    logic [PW-1:0] desc_clear_page = '0;
    logic [1:0]    outcome;
    logic          trap_req;
    logic [2:0]    stat_abort;
    logic          stat_trap;
    logic [PW-1:0] stat_page;
    logic [NP-1:0] acc_bits;
    logic [NP-1:0] wr_bits;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [2:0]    m_abort;
    logic          m_trap;
    logic [PW-1:0] m_page;
    logic [NP-1:0] m_acc;
    logic [NP-1:0] m_wr;

    always #4 clk = ~clk;

    pg_access_guard #(.NPAGE(NP), .BLK_W(BW)) u_pg_access_guard (
        .clk, .rst, .ref_valid, .ref_code, .ref_page, .ref_write, .trap_enable,
        .blk_num, .pg_len, .expand_down, .stat_clear, .desc_clear, .desc_clear_page,
        .outcome, .trap_req, .stat_abort, .stat_trap, .stat_page, .acc_bits, .wr_bits
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, "stat_abort", int'(stat_abort), int'(m_abort));
        chk(tag, "stat_trap",  int'(stat_trap),  int'(m_trap));
        chk(tag, "stat_page",  int'(stat_page),  int'(m_page));
        chk(tag, "acc_bits",   int'(acc_bits),   int'(m_acc));
        chk(tag, "wr_bits",    int'(wr_bits),    int'(m_wr));
    endtask

    task automatic model_zero();
        m_abort = '0; m_trap = 1'b0; m_page = '0; m_acc = '0; m_wr = '0;
    endtask

    // one reference; inputs driven after negedge, state checked after posedge
    task automatic do_ref(input int code, input int pg, input bit wr, input bit ten,
                          input int blk, input int len, input bit dn);
        bit nr, ro, pl, tc, ab, frz;
        int exp_out;
        string t_out, t_st;
        ref_valid = 1'b1; ref_code = 3'(code); ref_page = PW'(pg); ref_write = wr;
        trap_enable = ten; blk_num = BW'(blk); pg_len = BW'(len); expand_down = dn;
        nr  = (code == 0 || code == 3 || code == 7);
        ro  = !nr && wr && (code == 1 || code == 2);
        pl  = !nr && !ro && (dn ? (blk < len) : (blk > len));
        tc  = !nr && !ro && (wr ? (code == 4 || code == 5) : (code == 1 || code == 4));
        ab  = nr || ro || pl;
        frz = (m_abort != 3'b000);
        exp_out = ab ? 2 : (tc ? 1 : 0);
        t_out = nr ? "R1" : ro ? "R2" : pl ? "R3" : "R4";
        #1;
        chk(t_out, "outcome", int'(outcome), exp_out);
        chk("R5", "trap_req", int'(trap_req), int'(tc && ten && !m_trap));
        if (tc) begin m_trap = 1'b1; m_acc[pg] = 1'b1; end
        if (!frz) begin
            if (ab) begin
                m_abort = m_abort | {nr, pl, ro};
                m_page  = PW'(pg);
            end else if (tc && ten) begin
                m_page  = PW'(pg);
            end
        end
        if (wr && !ab) m_wr[pg] = 1'b1;
        t_st = frz ? "R9" : ab ? "R7" : (tc && ten) ? "R6" : wr ? "R8" : "R4";
        @(posedge clk); #1;
        chk_state(t_st);
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic do_clear(input bit st, input bit dc, input int pg);
        stat_clear = st; desc_clear = dc; desc_clear_page = PW'(pg);
        if (st) begin m_abort = '0; m_trap = 1'b0; m_page = '0; end
        if (dc) begin m_acc[pg] = 1'b0; m_wr[pg] = 1'b0; end
        @(posedge clk); #1;
        chk("R10", "after clear", 0, 0);
        chk_state("R10");
        @(negedge clk);
        stat_clear = 1'b0; desc_clear = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int n;
        model_zero();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk_state("R10");

        // R11: idle with busy-looking inputs changes nothing
        ref_code = 3'd4; ref_write = 1'b1; trap_enable = 1'b1; blk_num = 3'd7;
        @(negedge clk);
        chk("R11", "idle outcome", int'(outcome), 0);
        chk("R11", "idle trap_req", int'(trap_req), 0);
        @(posedge clk); #1;
        chk_state("R11");
        @(negedge clk);

        n = 0;
        for (int blk = 0; blk < 8; blk++)
            for (int len = 0; len < 8; len++)
                for (int dn = 0; dn < 2; dn++)
                    for (int code = 0; code < 8; code++)
                        for (int wr = 0; wr < 2; wr++)
                            for (int ten = 0; ten < 2; ten++) begin
                                if (n % 5 == 0 || n % 11 == 3)
                                    do_clear(n % 5 == 0, n % 11 == 3, (n / 3) % NP);
                                do_ref(code, (n * 3 + blk) % NP, wr[0], ten[0], blk, len, dn[0]);
                                n++;
                            end

        // R10: reset clears everything
        rst = 1'b1;
        model_zero();
        @(posedge clk); #1;
        chk_state("R10");
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule